// File: doc/BRIEF.md
# March-Sequence Memory Self-Test Controller

This block drives a one-bit-wide, single-port RAM through a fixed march algorithm and reports whether every read returned the value the algorithm expects. The algorithm is a chain of eighteen elements. Each element sweeps the whole address space, either upward or downward, and applies one, two or three operations (read 0, read 1, write 0, write 1) to an address before it moves to the next address. The sequence targets stuck-at cells and coupling faults between pairs and triples of cells, and costs thirty operations per cell.

A pulse on `start` launches a run. The controller issues one RAM operation per clock. The RAM returns read data one cycle after a read. On the first mismatch, the controller raises a sticky error flag and holds the address and the element index of that failure. The run always completes. A single-cycle `done` pulse marks the end, and at that point the error outputs are final. A new `start` clears the previous result.

Top module: `march_bist_ctrl`

## Requirements
- R1: While reset is active and after it is released, `done`, `err`, `mem_we` and `mem_re` are 0, and `err_addr` and `err_elem` are 0.
- R2: When `start` is sampled high in idle, the cycle that follows issues element 0's first operation: a write of 0 (`mem_we`=1, `mem_wdata`=0) to address 0.
- R3: Elements are numbered 0 to 17 in this order. 0: up W0. 1: up R0,W1. 2: down R1. 3: up R1,W0. 4: down R0. 5: down R0,W1. 6: up R1. 7: down R1,W0. 8: up R0. 9: up R0,W1,W0. 10: down R0. 11: down R0,W1,W0. 12: up R0. 13: up W1. 14: up R1,W0,W1. 15: down R1. 16: down R1,W0,W1. 17: up R1. Up runs from address 0 to DEPTH-1 and down runs the reverse. All operations of an element go to one address before the next address. A run therefore has 16·DEPTH reads and 14·DEPTH writes.
- R4: `done` is high for exactly one cycle. Counting the rising edge that samples `start` as edge 1, `done` is high after edge 30·DEPTH+2. It is never high together with a RAM operation.
- R5: There is at most one RAM operation per cycle: `mem_we` and `mem_re` are never both 1.
- R6: The data for a read issued in cycle t is taken from `mem_rdata` in cycle t+1. A difference from the expected bit (the low bit of the read code: R0 expects 0, R1 expects 1) sets `err`.
- R7: `err_addr` and `err_elem` hold the address and element index of the first mismatching read. Later mismatches change neither them nor `err`.
- R8: After a failure the run continues to the last element, and `done` arrives at the same cycle as in a clean run.
- R9: `start` is ignored while a run is in progress. `start` sampled in idle clears `err`, `err_addr` and `err_elem` from the next cycle.
- R10: With a fault-free RAM, `err` stays 0 for the whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launches a run when sampled in idle |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | 1 | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_rdata | input | 1 | RAM read data, one cycle after `mem_re` |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Sticky mismatch flag |
| err_addr | output | ADDR_W | Address of first mismatch |
| err_elem | output | 5 | Element index (0 to 17) of first mismatch |

## Verification
The comparison of a read overlaps the issue of the next operation. In the same cycle, the controller checks the returned bit and already drives a new address, which is either the same address for a following write or the neighbour for the next read. Coupling faults whose failing read is followed at once by a write to that same cell provoke this overlap, and so does a stuck-at-0 cell at the top address, where the descending read of address DEPTH-1 is followed by a read of DEPTH-2. The case passes only if the captured address and element are those of the failing read and not those of the operation issued beside its comparison. The final read's comparison also lands in the cycle just before `done`, so `done` is checked to arrive with the error result already settled.

// File: rtl/march_pkg.sv
// Package: shared types and the element program of the march sequence.
// Assumes a one-bit RAM. Operation code: bit 1 = write, bit 0 = data bit.
package march_pkg;

    localparam int NUM_ELEMS = 18;
    localparam int ELEM_W    = 5;

    typedef enum logic [1:0] {
        OP_R0 = 2'b00,
        OP_R1 = 2'b01,
        OP_W0 = 2'b10,
        OP_W1 = 2'b11
    } op_e;

    typedef struct packed {
        logic       up;     // 1: ascending sweep
        logic [1:0] nops;   // operations per address, 1..3
        op_e        op0;
        op_e        op1;
        op_e        op2;
    } elem_t;

    // Returns the program entry for one element index.
    function automatic elem_t elem_rom(input logic [ELEM_W-1:0] idx);
        elem_t e;
        case (idx)
            5'd0:    e = '{1'b1, 2'd1, OP_W0, OP_R0, OP_R0};
            5'd1:    e = '{1'b1, 2'd2, OP_R0, OP_W1, OP_R0};
            5'd2:    e = '{1'b0, 2'd1, OP_R1, OP_R0, OP_R0};
            5'd3:    e = '{1'b1, 2'd2, OP_R1, OP_W0, OP_R0};
            5'd4:    e = '{1'b0, 2'd1, OP_R0, OP_R0, OP_R0};
            5'd5:    e = '{1'b0, 2'd2, OP_R0, OP_W1, OP_R0};
            5'd6:    e = '{1'b1, 2'd1, OP_R1, OP_R0, OP_R0};
            5'd7:    e = '{1'b0, 2'd2, OP_R1, OP_W0, OP_R0};
            5'd8:    e = '{1'b1, 2'd1, OP_R0, OP_R0, OP_R0};
            5'd9:    e = '{1'b1, 2'd3, OP_R0, OP_W1, OP_W0};
            5'd10:   e = '{1'b0, 2'd1, OP_R0, OP_R0, OP_R0};
            5'd11:   e = '{1'b0, 2'd3, OP_R0, OP_W1, OP_W0};
            5'd12:   e = '{1'b1, 2'd1, OP_R0, OP_R0, OP_R0};
            5'd13:   e = '{1'b1, 2'd1, OP_W1, OP_R0, OP_R0};
            5'd14:   e = '{1'b1, 2'd3, OP_R1, OP_W0, OP_W1};
            5'd15:   e = '{1'b0, 2'd1, OP_R1, OP_R0, OP_R0};
            5'd16:   e = '{1'b0, 2'd3, OP_R1, OP_W0, OP_W1};
            5'd17:   e = '{1'b1, 2'd1, OP_R1, OP_R0, OP_R0};
            default: e = '{1'b1, 2'd1, OP_R0, OP_R0, OP_R0};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/march_addr_gen.sv
// Address sweeper: loads the first address of an element (0 or the top)
// and steps up or down one address at a time.
// Assumes load and step are never requested in the same cycle.
module march_addr_gen #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_up,
    input  logic              step,
    input  logic              dir_up,
    output logic [ADDR_W-1:0] addr,
    output logic              at_end
);
    localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

    // Address register: element start load or single step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= load_up ? '0 : TOP;
        else if (step)
            addr <= dir_up ? addr + 1'b1 : addr - 1'b1;
    end

    // Last address of the current sweep direction.
    always_comb at_end = dir_up ? (addr == TOP) : (addr == '0);

endmodule

// File: rtl/march_seq.sv
// Sequencer: walks element and operation indices, decides when the
// address moves and when the run ends. It drains one cycle for the final
// read's comparison and then pulses done for one cycle.
// Assumes the address generator reports the sweep end in the same cycle.
module march_seq
    import march_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              at_end,
    output logic              running,
    output op_e               op,
    output logic [ELEM_W-1:0] elem,
    output logic              dir_up,
    output logic              addr_load,
    output logic              addr_load_up,
    output logic              addr_step,
    output logic              clear,
    output logic              done
);
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN, S_FIN} state_e;

    state_e            state_q;
    logic [ELEM_W-1:0] elem_q;
    logic [1:0]        opi_q;
    elem_t             cur;
    elem_t             nxt;
    logic              op_last;
    logic              elem_last;
    logic              launch;
    logic              next_elem;

    // Decode the current element and the advance conditions.
    always_comb begin
        cur       = elem_rom(elem_q);
        nxt       = elem_rom(elem_q + 1'b1);
        running   = (state_q == S_RUN);
        launch    = (state_q == S_IDLE) && start;
        op_last   = (opi_q == cur.nops - 2'd1);
        elem_last = (elem_q == ELEM_W'(NUM_ELEMS - 1));
        next_elem = running && op_last && at_end && !elem_last;
        case (opi_q)
            2'd0:    op = cur.op0;
            2'd1:    op = cur.op1;
            default: op = cur.op2;
        endcase
    end

    // Address generator controls and status outputs.
    always_comb begin
        elem         = elem_q;
        dir_up       = cur.up;
        addr_load    = launch || next_elem;
        addr_load_up = launch ? elem_rom('0).up : nxt.up;
        addr_step    = running && op_last && !at_end;
        clear        = launch;
        done         = (state_q == S_FIN);
    end

    // State, element index and operation index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            elem_q  <= '0;
            opi_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (start) begin
                    state_q <= S_RUN;
                    elem_q  <= '0;
                    opi_q   <= '0;
                end
                S_RUN: begin
                    if (op_last) begin
                        opi_q <= '0;
                        if (at_end) begin
                            if (elem_last) state_q <= S_DRAIN;
                            else           elem_q  <= elem_q + 1'b1;
                        end
                    end else begin
                        opi_q <= opi_q + 2'd1;
                    end
                end
                S_DRAIN: state_q <= S_FIN;
                default: state_q <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/march_resp.sv
// Response checker: remembers what a read expects, compares the bit the
// RAM returns one cycle later, and latches the first failure.
// Assumes one cycle of read latency and clear only between runs.
module march_resp
    import march_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rd_issue,
    input  logic              exp_bit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ELEM_W-1:0] elem,
    input  logic              rdata,
    output logic              err,
    output logic [ADDR_W-1:0] err_addr,
    output logic [ELEM_W-1:0] err_elem
);
    logic              pend_q;
    logic              exp_q;
    logic [ADDR_W-1:0] paddr_q;
    logic [ELEM_W-1:0] pelem_q;
    logic              miss;

    // Hold the expectation of the read in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            exp_q   <= 1'b0;
            paddr_q <= '0;
            pelem_q <= '0;
        end else begin
            pend_q  <= rd_issue;
            exp_q   <= exp_bit;
            paddr_q <= addr;
            pelem_q <= elem;
        end
    end

    // Mismatch of the returned bit.
    always_comb miss = pend_q && (rdata != exp_q);

    // Sticky flag and first-failure capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            err      <= 1'b0;
            err_addr <= '0;
            err_elem <= '0;
        end else if (miss && !err) begin
            err      <= 1'b1;
            err_addr <= paddr_q;
            err_elem <= pelem_q;
        end
    end

endmodule

// File: rtl/march_bist_ctrl.sv
// Top: march self-test controller for a one-bit single-port RAM.
// Issues one operation per clock, checks reads one cycle later and
// reports done with the first failure. Assumes a RAM with 2**ADDR_W cells.
module march_bist_ctrl
    import march_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic              mem_rdata,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] err_addr,
    output logic [ELEM_W-1:0] err_elem
);
    logic              running;
    op_e               op;
    logic [ELEM_W-1:0] elem;
    logic              dir_up;
    logic              addr_load;
    logic              addr_load_up;
    logic              addr_step;
    logic              clear;
    logic              at_end;
    logic [ADDR_W-1:0] addr;

    march_seq i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .at_end       (at_end),
        .running      (running),
        .op           (op),
        .elem         (elem),
        .dir_up       (dir_up),
        .addr_load    (addr_load),
        .addr_load_up (addr_load_up),
        .addr_step    (addr_step),
        .clear        (clear),
        .done         (done)
    );

    march_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (addr_load),
        .load_up (addr_load_up),
        .step    (addr_step),
        .dir_up  (dir_up),
        .addr    (addr),
        .at_end  (at_end)
    );

    // RAM command decode from the current operation code.
    always_comb begin
        mem_addr  = addr;
        mem_wdata = op[0];
        mem_we    = running && op[1];
        mem_re    = running && !op[1];
    end

    march_resp #(.ADDR_W(ADDR_W)) i_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .rd_issue (mem_re),
        .exp_bit  (op[0]),
        .addr     (addr),
        .elem     (elem),
        .rdata    (mem_rdata),
        .err      (err),
        .err_addr (err_addr),
        .err_elem (err_elem)
    );

endmodule

// File: rtl/march_bist_checker.sv
// Checker: port-level properties of the march controller, bound to the top.
module march_bist_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_we,
    input logic              mem_re,
    input logic              done,
    input logic              err,
    input logic [ADDR_W-1:0] err_addr,
    input logic [4:0]        err_elem
);
    // R5: never a read and a write together
    a_r5_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R4: done lasts one cycle
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: no RAM traffic while done
    a_r4_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(mem_we || mem_re));

    // R7: flag stays set until a new start
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);

    // R7: captured failure does not move
    a_r7_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> ($stable(err_addr) && $stable(err_elem)));

    // R6: flag rises only two cycles after a read was issued
    a_r6_err_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(mem_re, 2));

    // R1: element index stays in range
    a_r1_elem_range: assert property (@(posedge clk) disable iff (!rst_n)
        err_elem <= 5'd17);

endmodule

bind march_bist_ctrl march_bist_checker #(.ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .done     (done),
    .err      (err),
    .err_addr (err_addr),
    .err_elem (err_elem)
);

// File: tb/test_march_bist_ctrl.sv
module test_march_bist_ctrl;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int RUN_CYC = 30 * DEPTH + 2;

    // fault kinds of the bench RAM model
    localparam logic [2:0] F_NONE = 3'd0, F_SA0 = 3'd1, F_SA1 = 3'd2,
                           F_CFUP = 3'd3, F_CFDN = 3'd4, F_SA1X2 = 3'd5;

    // {kind, victim/cell, aggressor/second cell, exp err, exp addr, exp elem}
    localparam int NV = 9;
    localparam logic [20:0] VEC [NV] = '{
        {F_NONE,  4'd0,  4'd0,  1'b0, 4'd0,  5'd0},
        {F_SA0,   4'd5,  4'd0,  1'b1, 4'd5,  5'd2},
        {F_SA0,   4'd15, 4'd0,  1'b1, 4'd15, 5'd2},
        {F_SA1,   4'd0,  4'd0,  1'b1, 4'd0,  5'd1},
        {F_SA1,   4'd9,  4'd0,  1'b1, 4'd9,  5'd1},
        {F_CFUP,  4'd10, 4'd3,  1'b1, 4'd10, 5'd1},
        {F_CFUP,  4'd4,  4'd12, 1'b1, 4'd4,  5'd5},
        {F_CFDN,  4'd7,  4'd2,  1'b1, 4'd7,  5'd3},
        {F_SA1X2, 4'd12, 4'd3,  1'b1, 4'd3,  5'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_wdata, mem_we, mem_re, mem_rdata, done, err;
    logic [AW-1:0] err_addr;
    logic [4:0]    err_elem;

    march_bist_ctrl #(.ADDR_W(AW)) i_march_bist_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .done(done), .err(err),
        .err_addr(err_addr), .err_elem(err_elem));

    always #10 clk = ~clk;   // 50 MHz

    int n_tests = 0;
    int n_fail  = 0;

    // RAM model with one injected fault, plus operation counters
    logic [2:0]       f_kind = F_NONE;
    logic [AW-1:0]    f_a = '0, f_g = '0;
    logic             ram_clr = 1'b0;
    logic [DEPTH-1:0] mem = '0;
    logic [DEPTH-1:0] nxt;
    logic             oldb, newb;
    int               n_rd = 0, n_wr = 0, n_both = 0;

    always @(posedge clk) begin
        if (ram_clr) begin
            mem  <= '0;
            n_rd = 0; n_wr = 0; n_both = 0;
        end else begin
            if (mem_we && mem_re) n_both++;
            if (mem_re) begin
                mem_rdata <= mem[mem_addr];
                n_rd++;
            end
            if (mem_we) begin
                n_wr++;
                nxt  = mem;
                oldb = mem[mem_addr];
                newb = mem_wdata;
                if (f_kind == F_SA0 && mem_addr == f_a) newb = 1'b0;
                if (f_kind == F_SA1 && mem_addr == f_a) newb = 1'b1;
                if (f_kind == F_SA1X2 && (mem_addr == f_a || mem_addr == f_g)) newb = 1'b1;
                nxt[mem_addr] = newb;
                if (f_kind == F_CFUP && mem_addr == f_g && !oldb && newb) nxt[f_a] = 1'b1;
                if (f_kind == F_CFDN && mem_addr == f_g && oldb && !newb) nxt[f_a] = 1'b0;
                if (f_kind == F_SA1X2) begin
                    nxt[f_a] = 1'b1;
                    nxt[f_g] = 1'b1;
                end
                mem <= nxt;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Prepare the RAM for a run with the given fault.
    task automatic setup(input logic [2:0] k, input logic [AW-1:0] a, input logic [AW-1:0] g);
        f_kind = k; f_a = a; f_g = g;
        ram_clr = 1'b1;
        @(posedge clk); #5;
        ram_clr = 1'b0;
    endtask

    // Pulse start and count edges until done (edge sampling start = 1).
    int cyc;
    int extra_at = -1;
    task automatic run_to_done();
        start = 1'b1;
        @(posedge clk); #5;
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < RUN_CYC + 100) begin
            @(posedge clk); #5;
            cyc++;
            if (cyc == extra_at) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #5;
        check(done == 0 && err == 0 && mem_we == 0 && mem_re == 0, "R1 reset outputs", {done, err, mem_we, mem_re}, 0);
        rst_n = 1'b1;
        @(posedge clk); #5;
        check(err_addr == 0 && err_elem == 0 && !mem_we && !mem_re, "R1 idle after reset", err_elem, 0);

        // table of fault vectors
        for (int v = 0; v < NV; v++) begin
            setup(VEC[v][20:18], VEC[v][17:14], VEC[v][13:10]);
            run_to_done();
            check(done == 1 && cyc == RUN_CYC, "R4 R8 done cycle", cyc, RUN_CYC);
            check(err == VEC[v][9], "R6 R10 err flag", err, VEC[v][9]);
            if (VEC[v][9]) begin
                check(err_addr == VEC[v][8:5], "R7 first fail addr", err_addr, VEC[v][8:5]);
                check(err_elem == VEC[v][4:0], "R7 first fail element", err_elem, VEC[v][4:0]);
            end
            check(n_rd == 16 * DEPTH, "R3 read count", n_rd, 16 * DEPTH);
            check(n_wr == 14 * DEPTH, "R3 write count", n_wr, 14 * DEPTH);
            check(n_both == 0, "R5 single op", n_both, 0);
            @(posedge clk); #5;
            check(done == 0, "R4 done one cycle", done, 0);
        end

        // R9: new start clears the error left by the last vector
        check(err == 1, "R9 err left set", err, 1);
        setup(F_NONE, '0, '0);
        start = 1'b1;
        @(posedge clk); #5;
        start = 1'b0;
        check(err == 0 && err_addr == 0 && err_elem == 0, "R9 clear on start", err, 0);
        // R2: first operation W0 at address 0
        check(mem_we == 1 && mem_wdata == 0 && mem_addr == 0, "R2 first op", {mem_we, mem_wdata, mem_addr}, 8'h20);
        // R3: element 1 starts after DEPTH cycles, R0 then W1 on one address
        repeat (DEPTH) @(posedge clk);
        #5;
        check(mem_re == 1 && mem_addr == 0, "R3 elem1 read addr 0", mem_addr, 0);
        @(posedge clk); #5;
        check(mem_we == 1 && mem_wdata == 1 && mem_addr == 0, "R3 elem1 write 1 addr 0", mem_addr, 0);
        @(posedge clk); #5;
        check(mem_re == 1 && mem_addr == 1, "R3 elem1 next address", mem_addr, 1);
        // R3: element 2 descends from the top address
        repeat (2 * DEPTH - 2) @(posedge clk);
        #5;
        check(mem_re == 1 && mem_addr == AW'(DEPTH - 1), "R3 elem2 starts at top", mem_addr, DEPTH - 1);
        @(posedge clk); #5;
        check(mem_re == 1 && mem_addr == AW'(DEPTH - 2), "R3 elem2 descends", mem_addr, DEPTH - 2);
        while (!done) begin
            @(posedge clk); #5;
        end
        @(posedge clk); #5;

        // R9: start in mid-run is ignored
        setup(F_SA1, 4'd6, '0);
        extra_at = 200;
        run_to_done();
        extra_at = -1;
        check(cyc == RUN_CYC, "R9 start ignored when busy", cyc, RUN_CYC);
        check(err == 1 && err_addr == 6 && err_elem == 1, "R9 result kept when busy", err_addr, 6);
        @(posedge clk); #5;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule